// File: doc/BRIEF.md
# Microprogrammed Sequencer with Preset Jumps

This block is a finite state machine whose behaviour lives entirely in a small control store. The state is a loadable binary counter, and its value addresses the store directly. The word at that address supplies three things. First, the output bits that drive the block's outputs while the counter stays there. Second, a selector that chooses which single condition input is tested in that state. Third, a jump address with a jump flag that together choose between moving to the next address in sequence and presetting the counter to a stored target.

The store is filled at elaboration from a parameter image. It can also be rewritten word by word through a load port, but only while the block is held in reset. Once running, the machine steps through its microprogram. In each cycle it holds, steps or jumps, depending on the tested condition and the flag.

The state-level actions are named HOLD, STEP and JUMP. HOLD keeps the counter, and is taken when the selected condition is low. STEP adds one to the counter, and is taken when the condition is high and the flag is clear. JUMP presets the counter to the stored target, and is taken when the condition is high and the flag is set. Reset forces address 0.

Top module: `rom_seq`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state counter becomes 0.
- R2: `out_o` always equals bits [OUT_W-1:0] of the store word addressed by the current state, and nothing else.
- R3: The selector field, bits [OUT_W+SEL_W-1:OUT_W] of the current word, picks one bit of `cond_in`. When that bit is low, the state is unchanged at the next edge, whatever the other condition bits and the jump flag are.
- R4: When the selected condition bit is high and the jump flag (bit WORD_W-1, the most significant bit) is 0, the state increments by one at the next edge.
- R5: When the selected condition bit is high and the jump flag is 1, the state takes the jump field, bits [OUT_W+SEL_W+ADDR_W-1:OUT_W+SEL_W], at the next edge. This holds also at the last address.
- R6: A STEP from address 2^ADDR_W-1 goes to address 0.
- R7: With `rst` and `ld_en` both high, `ld_data` is written to the word at `ld_addr` at the clock edge. A pulse on `ld_en` while `rst` is low changes no word.
- R8: Before any load, the store holds the image given by parameter `INIT`, with word i at bits [i*WORD_W +: WORD_W].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; also enables loading |
| cond_in | input | COND_N | External condition inputs |
| ld_en | input | 1 | Store write strobe, honoured only during reset |
| ld_addr | input | ADDR_W | Word address for a store write |
| ld_data | input | WORD_W | Word value for a store write |
| state_o | output | ADDR_W | Current state counter value |
| out_o | output | OUT_W | Output field of the current word |

## Verification
Two functions can fall in the same cycle at the top of the address space. One is the counter's natural wrap to 0 at the last address. The other is a JUMP stored in that same word. The bench first runs a program whose last word steps, and expects address 0 next. It then reloads only that word with the jump flag set and a target of 3, replays the same path, and expects address 3 rather than 0. It also sets the jump flag in a state whose selected condition is low, and expects the counter to hold, so the flag alone never triggers a preset.

// File: rtl/seq_pkg.sv
package seq_pkg;

    // Action taken by the state counter at the next clock edge
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_STEP = 2'd1,
        ACT_JUMP = 2'd2
    } act_e;

    function automatic int unsigned sel_width(input int unsigned n_cond);
        return (n_cond > 1) ? $clog2(n_cond) : 1;
    endfunction

endpackage

// File: rtl/seq_store.sv
module seq_store #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned WORD_W = 11,
    parameter int unsigned DEPTH  = 1 << ADDR_W,
    parameter logic [DEPTH*WORD_W-1:0] INIT = '0
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem [DEPTH];

    // Elaboration-time image
    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = INIT[i*WORD_W +: WORD_W];
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/seq_decode.sv
module seq_decode
    import seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned COND_N = 4,
    parameter int unsigned OUT_W  = 4,
    parameter int unsigned SEL_W  = sel_width(COND_N),
    parameter int unsigned WORD_W = 1 + ADDR_W + SEL_W + OUT_W
) (
    input  logic [WORD_W-1:0] word,
    input  logic [COND_N-1:0] cond_in,
    output logic [OUT_W-1:0]  outs,
    output logic [ADDR_W-1:0] jaddr,
    output act_e              act
);
    localparam int unsigned SEL_LO  = OUT_W;
    localparam int unsigned JMP_LO  = OUT_W + SEL_W;
    localparam int unsigned FLAG_BT = WORD_W - 1;

    logic [SEL_W-1:0] sel;
    logic             flag;
    logic             hit;

    assign outs  = word[OUT_W-1:0];
    assign sel   = word[SEL_LO +: SEL_W];
    assign jaddr = word[JMP_LO +: ADDR_W];
    assign flag  = word[FLAG_BT];

    // Condition multiplexer; a selector beyond the last input reads as false
    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < COND_N; i++) begin
            if (32'(sel) == i) begin
                hit = cond_in[i];
            end
        end
    end

    always_comb begin
        unique case ({hit, flag})
            2'b10:   act = ACT_STEP;
            2'b11:   act = ACT_JUMP;
            default: act = ACT_HOLD;
        endcase
    end
endmodule

// File: rtl/seq_nextaddr.sv
module seq_nextaddr
    import seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  act_e              act,
    input  logic [ADDR_W-1:0] cur,
    input  logic [ADDR_W-1:0] jaddr,
    output logic [ADDR_W-1:0] nxt
);
    always_comb begin
        unique case (act)
            ACT_STEP: nxt = cur + 1'b1;   // wraps naturally at the top
            ACT_JUMP: nxt = jaddr;
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/rom_seq.sv
module rom_seq
    import seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned COND_N = 4,
    parameter int unsigned OUT_W  = 4,
    parameter int unsigned SEL_W  = sel_width(COND_N),
    parameter int unsigned WORD_W = 1 + ADDR_W + SEL_W + OUT_W,
    parameter int unsigned DEPTH  = 1 << ADDR_W,
    parameter logic [DEPTH*WORD_W-1:0] INIT = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [COND_N-1:0] cond_in,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [WORD_W-1:0] ld_data,
    output logic [ADDR_W-1:0] state_o,
    output logic [OUT_W-1:0]  out_o
);
    logic [ADDR_W-1:0] state_q;
    logic [ADDR_W-1:0] state_d;
    logic [ADDR_W-1:0] jaddr;
    logic [WORD_W-1:0] cur_word;
    logic [OUT_W-1:0]  outs;
    act_e              act;

    seq_store #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W),
        .DEPTH  (DEPTH),
        .INIT   (INIT)
    ) u_store (
        .clk   (clk),
        .we    (rst & ld_en),
        .waddr (ld_addr),
        .wdata (ld_data),
        .raddr (state_q),
        .rdata (cur_word)
    );

    seq_decode #(
        .ADDR_W (ADDR_W),
        .COND_N (COND_N),
        .OUT_W  (OUT_W),
        .SEL_W  (SEL_W),
        .WORD_W (WORD_W)
    ) u_decode (
        .word    (cur_word),
        .cond_in (cond_in),
        .outs    (outs),
        .jaddr   (jaddr),
        .act     (act)
    );

    seq_nextaddr #(
        .ADDR_W (ADDR_W)
    ) u_next (
        .act   (act),
        .cur   (state_q),
        .jaddr (jaddr),
        .nxt   (state_d)
    );

    // State register process
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // Output process (Moore: current word only)
    always_comb begin
        state_o = state_q;
        out_o   = outs;
    end
endmodule

// File: rtl/rom_seq_chk.sv
module rom_seq_chk #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned COND_N = 4,
    parameter int unsigned OUT_W  = 4,
    parameter int unsigned SEL_W  = 2,
    parameter int unsigned WORD_W = 1 + ADDR_W + SEL_W + OUT_W
) (
    input logic              clk,
    input logic              rst,
    input logic [COND_N-1:0] cond_in,
    input logic [ADDR_W-1:0] state_o,
    input logic [WORD_W-1:0] cur_word
);
    logic [SEL_W-1:0]  c_sel;
    logic              c_flag;
    logic [ADDR_W-1:0] c_tgt;
    logic              c_true;

    assign c_sel  = cur_word[OUT_W +: SEL_W];
    assign c_flag = cur_word[WORD_W-1];
    assign c_tgt  = cur_word[OUT_W+SEL_W +: ADDR_W];
    assign c_true = (32'(c_sel) < COND_N) ? cond_in[c_sel] : 1'b0;

    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> (state_o == '0));

    assert_hold_on_false_R3: assert property (@(posedge clk) disable iff (rst)
        !c_true |=> $stable(state_o));

    assert_step_R4: assert property (@(posedge clk) disable iff (rst)
        (c_true && !c_flag) |=> (state_o == ADDR_W'($past(state_o) + 1'b1)));

    assert_jump_R5: assert property (@(posedge clk) disable iff (rst)
        (c_true && c_flag) |=> (state_o == $past(c_tgt)));

    assert_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (c_true && !c_flag && (&state_o)) |=> (state_o == '0));
endmodule

bind rom_seq rom_seq_chk #(
    .ADDR_W (ADDR_W),
    .COND_N (COND_N),
    .OUT_W  (OUT_W),
    .SEL_W  (SEL_W),
    .WORD_W (WORD_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cond_in  (cond_in),
    .state_o  (state_o),
    .cur_word (cur_word)
);

// File: tb/test_rom_seq.sv
module test_rom_seq;
    localparam int unsigned AW    = 4;
    localparam int unsigned CN    = 4;
    localparam int unsigned OW    = 4;
    localparam int unsigned SW    = 2;
    localparam int unsigned WW    = 1 + AW + SW + OW;
    localparam int unsigned DEPTH = 1 << AW;

    // Word layout: {flag[WW-1], jump[AW], sel[SW], out[OW]}
    function automatic logic [WW-1:0] mkw(input logic f, input logic [AW-1:0] j,
                                          input logic [SW-1:0] s, input logic [OW-1:0] o);
        return {f, j, s, o};
    endfunction

    function automatic logic [DEPTH*WW-1:0] mk_init();
        logic [DEPTH*WW-1:0] v;
        v = '0;
        for (int i = 0; i < DEPTH; i++) begin
            v[i*WW +: WW] = mkw(1'b0, '0, SW'(i % CN), OW'(i * 3 + 1));
        end
        return v;
    endfunction

    localparam logic [DEPTH*WW-1:0] INIT_IMG = mk_init();

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CN-1:0] cond_in = '0;
    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [WW-1:0] ld_data = '0;
    logic [AW-1:0] state_o;
    logic [OW-1:0] out_o;

    int n_chk = 0;
    int n_bad = 0;

    logic [WW-1:0] img [DEPTH];
    logic [AW-1:0] ms;

    always #10 clk = ~clk;

    rom_seq #(.ADDR_W(AW), .COND_N(CN), .OUT_W(OW), .INIT(INIT_IMG)) i_rom_seq (
        .clk(clk), .rst(rst), .cond_in(cond_in), .ld_en(ld_en),
        .ld_addr(ld_addr), .ld_data(ld_data), .state_o(state_o), .out_o(out_o)
    );

    task automatic check(input string tag);
        logic [OW-1:0] eo;
        eo = img[ms][OW-1:0];
        n_chk++;
        if (state_o !== ms) begin
            n_bad++;
            $display("FAIL %s state actual=%0d expected=%0d", tag, state_o, ms);
        end
        n_chk++;
        if (out_o !== eo) begin
            n_bad++;
            $display("FAIL %s out actual=%0h expected=%0h", tag, out_o, eo);
        end
    endtask

    // One running cycle: drive at negedge, model at posedge, check at next negedge
    task automatic cyc(input logic [CN-1:0] c, input string tag);
        logic [WW-1:0] w;
        cond_in = c;
        w = img[ms];
        @(posedge clk);
        if (c[w[OW +: SW]]) begin
            ms = w[WW-1] ? w[OW+SW +: AW] : AW'(ms + 1'b1);
        end
        @(negedge clk);
        check(tag);
    endtask

    task automatic t_reset(input string tag);
        rst = 1'b1;
        cond_in = '1;
        @(posedge clk);
        ms = '0;
        @(negedge clk);
        check(tag);
    endtask

    task automatic load(input logic [AW-1:0] a, input logic [WW-1:0] w);
        ld_en = 1'b1; ld_addr = a; ld_data = w;
        @(posedge clk);
        @(negedge clk);
        ld_en = 1'b0;
        img[a] = w;
    endtask

    task automatic t_init_image();
        t_reset("R1 reset");
        rst = 1'b0;
        check("R8 R2 image word0");
        cyc(4'b1111, "R8 R4 image step");
        cyc(4'b1111, "R8 R4 image step");
        cyc(4'b1111, "R8 R2 image step");
    endtask

    task automatic t_program();
        t_reset("R1 reset before load");
        for (int i = 0; i < DEPTH; i++) load(AW'(i), mkw(1'b0, '0, '0, OW'(i)));
        load(4'd0,  mkw(1'b0, 4'd0,  2'd0, 4'h1));
        load(4'd1,  mkw(1'b0, 4'd0,  2'd1, 4'h2));
        load(4'd2,  mkw(1'b1, 4'd5,  2'd2, 4'h4));
        load(4'd5,  mkw(1'b0, 4'd0,  2'd3, 4'h8));
        load(4'd6,  mkw(1'b1, 4'd15, 2'd0, 4'h9));
        load(4'd15, mkw(1'b0, 4'd0,  2'd1, 4'hA));
        @(negedge clk);
        ms = '0;
        check("R1 R7 loaded word0 during reset");
        rst = 1'b0;
    endtask

    task automatic t_hold_and_step();
        cyc(4'b1110, "R3 hold, other bits high");
        cyc(4'b0000, "R3 hold, all low");
        cyc(4'b0001, "R4 step on sel0");
        cyc(4'b1101, "R3 hold sel1 low");
        cyc(4'b0010, "R4 step on sel1");
    endtask

    task automatic t_jump_path();
        cyc(4'b1011, "R3 hold with flag set");
        cyc(4'b0100, "R5 jump to 5");
        cyc(4'b1000, "R4 step 5 to 6");
        cyc(4'b0001, "R5 jump to 15");
    endtask

    task automatic t_wrap();
        cyc(4'b0010, "R6 wrap 15 to 0");
    endtask

    task automatic t_load_ignored();
        ld_en = 1'b1; ld_addr = 4'd0; ld_data = mkw(1'b1, 4'd7, 2'd3, 4'h6);
        cyc(4'b0000, "R7 write ignored when running");
        ld_en = 1'b0;
        cyc(4'b0001, "R7 word0 still steps");
        ms = ms;
    endtask

    task automatic t_jump_at_top();
        t_reset("R1 reset before top jump");
        load(4'd15, mkw(1'b1, 4'd3, 2'd2, 4'hB));
        load(4'd3,  mkw(1'b0, 4'd0, 2'd0, 4'h3));
        rst = 1'b0;
        cyc(4'b0001, "R4 path 0->1");
        cyc(4'b0010, "R4 path 1->2");
        cyc(4'b0100, "R5 path 2->5");
        cyc(4'b1000, "R4 path 5->6");
        cyc(4'b0001, "R5 path 6->15");
        cyc(4'b1011, "R3 hold at 15 with flag");
        cyc(4'b0100, "R5 R6 jump beats wrap at 15");
        cyc(4'b0001, "R4 step after top jump");
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) img[i] = INIT_IMG[i*WW +: WW];
        ms = '0;
        @(negedge clk);
        t_init_image();
        t_program();
        t_hold_and_step();
        t_jump_path();
        t_wrap();
        t_load_ignored();
        t_jump_at_top();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog all requirements actual=timeout expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule